// File: doc/BRIEF.md
# Fractional Clock Divider Channel

This block is one channel of a numerically controlled clock divider. It runs on a reference clock at twice the rate of the input clock being divided, so one reference cycle (a "tick") is half an input cycle. It produces `clk_out`, whose long-term average period is an integer divisor plus a fraction. A 32-bit phase accumulator decides, period by period, whether the current period gets one extra tick.

The integer divisor has two fields. The fine field is a 2-bit binary count. The coarse field is not a binary number: it is a state of an 11-bit Galois LFSR. The LFSR starts from that state and counts until it reaches a fixed end state. Software writes the enable bit, the divisor, two accumulator increments and an accumulator start value through a small 32-bit register port.

While a period runs, the accumulator's top bit does two jobs. It stretches the period by one tick, and it chooses which increment is added when the period ends. Software normally keeps the first increment below 2^31 and the second increment negative. This keeps the accumulator swinging around its midpoint. A start value of 0x8000_0000 gives a neutral starting phase.

Top module: `nco_channel`

## Requirements
- R1: After reset, `clk_out` is low and every register reads back as zero.
- R2: The registers sit at these byte offsets:
  - 0: control. Bit 31 is the enable; all other bits read 0.
  - 4: divisor. Bits 1:0 are the fine count and bits 12:2 are the coarse LFSR state; bits above read 0.
  - 8: first increment.
  - 12: second increment.
  - 16: accumulator start value.
  Each implemented field reads back what was last written to it.
- R3: A write to any other address changes no register and does not start the output.
- R4: Coarse value 2 is encoded as state 0. A coarse value c from 3 to 2049 is encoded as the LFSR state reached after 2050−c steps from 0x7FF. One LFSR step shifts the state right by one bit, then XORs 0x500 into it if the bit shifted out was 1.
- R5: When the accumulator top bit is clear, one output period lasts 4c+f ticks, where c is the coarse value and f is the fine count.
- R6: Let e = f + top bit. In each period `clk_out` is high for 2c+floor(e/2) ticks first, then low for 2c+ceil(e/2) ticks.
- R7: When the accumulator top bit is set, the period lasts 4c+f+1 ticks.
- R8: At the end of each period the accumulator adds the first increment if its top bit was clear, or the second increment if the top bit was set. The sum wraps modulo 2^32.
- R9: Let W be the clock edge that writes the enable bit from 0 to 1. At the next edge the accumulator loads the start value, and `clk_out` goes high at that same edge.
- R10: Let W be the clock edge that writes the enable bit to 0. From the next edge on, `clk_out` is low and stays low until the output is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the input clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench builds the channel with a 4-bit LFSR (taps 0xC, end state 0xF), so coarse values run from 2 to 17. With this setting it can sweep every coarse value against every fine count and check the high and low time of each period exactly. The same encoding rule, with wider LFSR and larger table, applies at the default width. The accumulator stays 32 bits wide. Several increment and start-value sets then drive runs of many periods, so that both increments are selected and the top bit flips back and forth, including the case where a set top bit combines with fine count 3.

// File: rtl/nco_pkg.sv
package nco_pkg;

   localparam int REG_W      = 32;
   localparam int FINE_W     = 2;
   localparam int MIN_COARSE = 2;

   typedef enum logic [2:0] {
      RSEL_CTL,
      RSEL_DIV,
      RSEL_INCA,
      RSEL_INCB,
      RSEL_INIT,
      RSEL_NONE
   } rsel_e;

   // Byte offsets of the channel registers; a full match is required.
   function automatic rsel_e addr_decode(input logic [REG_W-1:0] a);
      case (a)
         32'd0:   return RSEL_CTL;
         32'd4:   return RSEL_DIV;
         32'd8:   return RSEL_INCA;
         32'd12:  return RSEL_INCB;
         32'd16:  return RSEL_INIT;
         default: return RSEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/nco_regs.sv
module nco_regs
   import nco_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int LFSR_W = 11,
   parameter int ACC_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              en,
   output logic [LFSR_W-1:0] coarse_state,
   output logic [FINE_W-1:0] fine,
   output logic [ACC_W-1:0]  inc_a,
   output logic [ACC_W-1:0]  inc_b,
   output logic [ACC_W-1:0]  init
);

   localparam int DIV_W = FINE_W + LFSR_W;

   logic             en_q;
   logic [DIV_W-1:0] div_q;
   logic [ACC_W-1:0] inca_q, incb_q, init_q;
   rsel_e            wsel, rsel;

   assign wsel = addr_decode(REG_W'(wr_addr));
   assign rsel = addr_decode(REG_W'(rd_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         div_q  <= '0;
         inca_q <= '0;
         incb_q <= '0;
         init_q <= '0;
      end else if (wr_en) begin
         case (wsel)
            RSEL_CTL:  en_q   <= wr_data[REG_W-1];
            RSEL_DIV:  div_q  <= wr_data[DIV_W-1:0];
            RSEL_INCA: inca_q <= wr_data[ACC_W-1:0];
            RSEL_INCB: incb_q <= wr_data[ACC_W-1:0];
            RSEL_INIT: init_q <= wr_data[ACC_W-1:0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rsel)
         RSEL_CTL:  rd_data[REG_W-1]   = en_q;
         RSEL_DIV:  rd_data[DIV_W-1:0] = div_q;
         RSEL_INCA: rd_data[ACC_W-1:0] = inca_q;
         RSEL_INCB: rd_data[ACC_W-1:0] = incb_q;
         RSEL_INIT: rd_data[ACC_W-1:0] = init_q;
         default:   rd_data = '0;
      endcase
   end

   assign en           = en_q;
   assign fine         = div_q[FINE_W-1:0];
   assign coarse_state = div_q[DIV_W-1:FINE_W];
   assign inc_a        = inca_q;
   assign inc_b        = incb_q;
   assign init         = init_q;

endmodule

// File: rtl/nco_half_timer.sv
// Times one half of an output period: an LFSR phase stepping once per two
// ticks, then a short binary tail that absorbs the fixed offset and extra ticks.
module nco_half_timer
   import nco_pkg::*;
#(
   parameter int                LFSR_W    = 11,
   parameter logic [LFSR_W-1:0] TAP_MASK  = 11'h500,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 11'h7FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LFSR_W-1:0] coarse_state,
   input  logic [2:0]        extra,
   input  logic              tick,
   output logic              done
);

   localparam int                TAIL_MAX  = 2 * (MIN_COARSE + 1) + 3;
   localparam int                REM_W     = $clog2(TAIL_MAX + 1);
   localparam logic [REM_W-1:0]  BASE_ZERO = REM_W'(2 * MIN_COARSE);
   localparam logic [REM_W-1:0]  BASE_SEED = REM_W'(2 * (MIN_COARSE + 1));

   logic [LFSR_W-1:0] lfsr_q, lfsr_step;
   logic              sub_q, tail_q;
   logic [REM_W-1:0]  rem_q, rem_load;
   logic              direct_tail;

   assign lfsr_step   = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAP_MASK : '0);
   assign direct_tail = (coarse_state == '0) || (coarse_state == LFSR_SEED);
   assign rem_load    = ((coarse_state == '0) ? BASE_ZERO : BASE_SEED)
                        + REM_W'(extra) - REM_W'(1);
   assign done        = tick && tail_q && (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= '0;
         sub_q  <= 1'b0;
         tail_q <= 1'b0;
         rem_q  <= '0;
      end else if (load) begin
         lfsr_q <= coarse_state;
         sub_q  <= 1'b0;
         tail_q <= direct_tail;
         rem_q  <= rem_load;
      end else if (tick) begin
         if (!tail_q) begin
            if (sub_q) begin
               lfsr_q <= lfsr_step;
               sub_q  <= 1'b0;
               if (lfsr_step == LFSR_SEED) tail_q <= 1'b1;
            end else begin
               sub_q <= 1'b1;
            end
         end else if (rem_q != '0) begin
            rem_q <= rem_q - REM_W'(1);
         end
      end
   end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ACC_W-1:0] init,
   input  logic             advance,
   input  logic [ACC_W-1:0] inc_a,
   input  logic [ACC_W-1:0] inc_b,
   output logic [ACC_W-1:0] acc,
   output logic             msb_next
);

   logic [ACC_W-1:0] acc_q, acc_d, sum;

   assign sum      = acc_q + (acc_q[ACC_W-1] ? inc_b : inc_a);
   assign acc_d    = load ? init : (advance ? sum : acc_q);
   assign msb_next = acc_d[ACC_W-1];
   assign acc      = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

endmodule

// File: rtl/nco_channel.sv
module nco_channel
   import nco_pkg::*;
#(
   parameter int                ADDR_W    = 5,
   parameter int                LFSR_W    = 11,
   parameter logic [LFSR_W-1:0] TAP_MASK  = 11'h500,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 11'h7FF,
   parameter int                ACC_W     = 32,
   parameter bit                OUT_FLOP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              clk_out
);

   generate
      if (LFSR_W < 3 || LFSR_W > REG_W - FINE_W) begin : g_bad_lfsr
         $error("nco_channel: LFSR_W out of range");
      end
      if (ACC_W < 2 || ACC_W > REG_W) begin : g_bad_acc
         $error("nco_channel: ACC_W out of range");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("nco_channel: ADDR_W too small for the register map");
      end
      if (LFSR_SEED == '0) begin : g_bad_seed
         $error("nco_channel: LFSR end state must be nonzero");
      end
   endgenerate

   logic              en;
   logic [LFSR_W-1:0] coarse_state;
   logic [FINE_W-1:0] fine;
   logic [ACC_W-1:0]  inc_a, inc_b, init, acc_q;
   logic              msb_next;
   logic              run_q, half_q;
   logic              tick, prime, done, load_second, period_end, timer_load;
   logic [2:0]        e_sum, x_lo, x_hi, extra;
   logic              run_d, half_d;

   nco_regs #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W), .ACC_W(ACC_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .en           (en),
      .coarse_state (coarse_state),
      .fine         (fine),
      .inc_a        (inc_a),
      .inc_b        (inc_b),
      .init         (init)
   );

   assign tick        = run_q & en;
   assign prime       = en & ~run_q;
   assign load_second = done & ~half_q;
   assign period_end  = done & half_q;
   assign timer_load  = prime | done;

   nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (prime),
      .init     (init),
      .advance  (period_end),
      .inc_a    (inc_a),
      .inc_b    (inc_b),
      .acc      (acc_q),
      .msb_next (msb_next)
   );

   // Extra ticks of a period split between its halves; the low half takes the odd one.
   assign e_sum = 3'(fine) + 3'(msb_next);
   assign x_lo  = e_sum >> 1;
   assign x_hi  = e_sum - x_lo;
   assign extra = load_second ? x_hi : x_lo;

   nco_half_timer #(.LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK), .LFSR_SEED(LFSR_SEED)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (timer_load),
      .coarse_state (coarse_state),
      .extra        (extra),
      .tick         (tick),
      .done         (done)
   );

   assign run_d  = en;
   assign half_d = prime ? 1'b0 : (done ? ~half_q : half_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         half_q <= 1'b0;
      end else begin
         run_q  <= run_d;
         half_q <= half_d;
      end
   end

   generate
      if (OUT_FLOP) begin : g_out_flop
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= run_d & ~half_d;
         end
         assign clk_out = out_q;
      end else begin : g_out_gate
         assign clk_out = run_q & ~half_q;
      end
   endgenerate

endmodule

// File: rtl/nco_channel_chk.sv
module nco_channel_chk #(
   parameter int ADDR_W = 5,
   parameter int LFSR_W = 11,
   parameter int ACC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              run_q,
   input logic              half_q,
   input logic              done,
   input logic [ACC_W-1:0]  acc_q,
   input logic [ACC_W-1:0]  inc_a,
   input logic [ACC_W-1:0]  inc_b,
   input logic [ACC_W-1:0]  init,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [31:0]       rd_data,
   input logic              clk_out
);

   AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !clk_out); // R10

   AST_START_LOADS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !run_q) |=> (acc_q == $past(init) && clk_out)); // R9

   AST_ACC_STILL_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && !(done && half_q)) |=> (acc_q == $past(acc_q))); // R8

   AST_ACC_STEP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && done && half_q) |=>
         (acc_q == $past(acc_q) + ($past(acc_q[ACC_W-1]) ? $past(inc_b) : $past(inc_a)))); // R8

   AST_OUT_STEADY_MIDHALF: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && !done) |=> (clk_out == $past(clk_out))); // R6

   AST_DIV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(4)) |-> ((rd_data >> (2 + LFSR_W)) == 32'd0)); // R2

   AST_CTL_ONLY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(0)) |-> (rd_data[30:0] == 31'd0)); // R2

endmodule

bind nco_channel nco_channel_chk #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W), .ACC_W(ACC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .run_q   (run_q),
   .half_q  (half_q),
   .done    (done),
   .acc_q   (acc_q),
   .inc_a   (inc_a),
   .inc_b   (inc_b),
   .init    (init),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .clk_out (clk_out)
);

// File: tb/tb_nco_channel.sv
`timescale 1ns/1ps
module tb_nco_channel;

   localparam int         LW   = 4;
   localparam logic [3:0] TAPS = 4'hC;
   localparam logic [3:0] ENDS = 4'hF;
   localparam int         AW   = 5;
   localparam int         CMAX = (1 << LW) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic          clk_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [LW-1:0] enc [2:CMAX];

   always #2.5 clk = ~clk;

   nco_channel #(.ADDR_W(AW), .LFSR_W(LW), .TAP_MASK(TAPS), .LFSR_SEED(ENDS)) dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .clk_out (clk_out)
   );

   function automatic logic [LW-1:0] lstep(input logic [LW-1:0] s);
      return {1'b0, s[LW-1:1]} ^ (s[0] ? TAPS : '0);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic measure(output int h, output int l);
      h = 0; l = 0;
      while (clk_out === 1'b1 && h < 5000) begin h++; @(negedge clk); end
      while (clk_out === 1'b0 && l < 5000) begin l++; @(negedge clk); end
   endtask

   // Program a channel and enable it; returns at the first high sample.
   task automatic start(input int c, input int f, input logic [31:0] ia,
                        input logic [31:0] ib, input logic [31:0] ini);
      wr(0, 32'h0);
      wr(4, {26'd0, enc[c], f[1:0]});
      wr(8, ia);
      wr(12, ib);
      wr(16, ini);
      wr(0, 32'h8000_0000);
      chk("R9 low before start edge", {31'd0, clk_out}, 32'd0);
      @(negedge clk);
      chk("R9 high after start edge", {31'd0, clk_out}, 32'd1);
   endtask

   task automatic acc_run(input int c, input int f, input logic [31:0] ia,
                          input logic [31:0] ib, input logic [31:0] ini, input int nper);
      logic [31:0] acc;
      int h, l, e;
      start(c, f, ia, ib, ini);
      acc = ini;
      for (int k = 0; k < nper; k++) begin
         e = f + int'(acc[31]);
         measure(h, l);
         chk("R6 high time", h, 2*c + e/2);
         if (acc[31]) chk("R7 stretched period", h + l, 4*c + f + 1);
         else         chk("R5 plain period", h + l, 4*c + f);
         if (k > 0) chk("R8 low time follows accumulator", l, 2*c + e - e/2);
         acc = acc + (acc[31] ? ib : ia);
      end
   endtask

   initial begin
      logic [31:0] d;
      int h, l;
      logic [LW-1:0] s;

      enc[2] = '0;
      for (int c = 3; c <= CMAX; c++) begin
         s = ENDS;
         for (int k = 0; k < (1 << LW) + 2 - c; k++) s = lstep(s);
         enc[c] = s;
      end

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 clk_out after reset", {31'd0, clk_out}, 32'd0);
      for (int a = 0; a <= 16; a += 4) begin
         rd(AW'(a), d);
         chk("R1 register reset value", d, 32'd0);
      end

      // R2: readback with unimplemented bits
      wr(0, 32'h7FFF_FFFF);
      rd(0, d);  chk("R2 control keeps only enable", d, 32'd0);
      wr(4, 32'hFFFF_FFFF);
      rd(4, d);  chk("R2 divisor field width", d, (32'd1 << (2 + LW)) - 1);
      wr(8, 32'h1234_5678);
      wr(12, 32'hDEAD_BEEF);
      wr(16, 32'h8000_0001);
      rd(8, d);  chk("R2 first increment", d, 32'h1234_5678);
      rd(12, d); chk("R2 second increment", d, 32'hDEAD_BEEF);
      rd(16, d); chk("R2 start value", d, 32'h8000_0001);

      // R3: writes outside the map
      wr(20, 32'hFFFF_FFFF);
      wr(24, 32'h0);
      wr(2, 32'h8000_0000);
      wr(1, 32'h0);
      repeat (5) @(negedge clk);
      chk("R3 no enable from stray write", {31'd0, clk_out}, 32'd0);
      rd(0, d);  chk("R3 control untouched", d, 32'd0);
      rd(4, d);  chk("R3 divisor untouched", d, (32'd1 << (2 + LW)) - 1);
      rd(8, d);  chk("R3 first increment untouched", d, 32'h1234_5678);
      rd(12, d); chk("R3 second increment untouched", d, 32'hDEAD_BEEF);
      rd(16, d); chk("R3 start value untouched", d, 32'h8000_0001);

      // R4/R5/R6: every coarse value against every fine count
      for (int c = 2; c <= CMAX; c++) begin
         for (int f = 0; f < 4; f++) begin
            start(c, f, 32'h0, 32'h0, 32'h0);
            measure(h, l);
            chk("R4 R6 high time", h, 2*c + f/2);
            chk("R4 R5 period", h + l, 4*c + f);
         end
      end

      // R10: disable holds output low
      wr(0, 32'h0);
      @(negedge clk);
      for (int k = 0; k < 40; k++) begin
         if (k == 0 || k == 39) chk("R10 low after disable", {31'd0, clk_out}, 32'd0);
         else if (clk_out !== 1'b0) chk("R10 stays low", {31'd0, clk_out}, 32'd0);
         @(negedge clk);
      end

      // R7/R8/R9: accumulator sequences
      acc_run(5, 1, 32'h4000_0000, 32'hC000_0000, 32'h8000_0000, 12);
      acc_run(9, 2, 32'h5555_5555, 32'h9000_0000, 32'h0000_0000, 16);
      acc_run(2, 3, 32'h2000_0000, 32'hA000_0000, 32'h8000_0000, 10);
      acc_run(CMAX, 0, 32'h7FFF_FFFF, 32'h8000_0001, 32'hFFFF_FFFF, 8);
      acc_run(3, 3, 32'h1000_0000, 32'hF000_0000, 32'h7000_0000, 20);
      wr(0, 32'h0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule